// File: doc/BRIEF.md
# Audio Frame Clock Unit (Master/Slave)

This block either produces or follows the bit clock and the word-select (left/right) clock of a serial audio link. In master role, a synchronous up-counter runs from the system clock. One counter bit serves as the bit clock and the top counter bit serves as the word-select clock, so their phases stay fixed relative to each other. With a 12.288 MHz system clock and an 8-bit counter, the word-select clock runs at 48 kHz and the bit clock runs at 32 times that rate.

In slave role, the codec drives both clocks. The block never uses them as clocks: it samples them as plain data through a two-flop synchroniser. In both roles, the block compares each level with its registered previous value. This gives one-cycle rise and fall strobes, a channel indication and a frame-start strobe. A mode input selects the role at run time. Shifting the audio samples is handled outside this block.

Top module: `audio_frame_clk`

## Requirements
- R1: In master role (`slave_mode`=0), `lrck_out` equals bit 7 of the count of system clock edges since reset or since leaving slave role. It has a period of 256 cycles, with 128 cycles low followed by 128 cycles high.
- R2: In master role, `bclk_out` equals bit 2 of the same count. That gives a period of 8 cycles and 32 bit clock periods per frame. Every `lrck_out` change falls on a cycle in which `bclk_out` goes from 1 to 0.
- R3: In master role, `bclk_rise`, `bclk_fall`, `lrck_rise` and `lrck_fall` are each high for exactly the one cycle in which the matching output has just changed to 1 (rise) or to 0 (fall).
- R4: In slave role (`slave_mode`=1), a level applied to `bclk_in` or `lrck_in` reaches the internal level after two system clock edges. The matching rise or fall strobe is high for exactly the one cycle that follows that second edge.
- R5: In slave role, `bclk_out` and `lrck_out` are 0 and the counter is held at 0. On return to master role, counting restarts from 0, so the first word-select low half lasts the full 128 cycles.
- R6: `right_ch` follows the selected word-select level, with 1 meaning the right channel. `frame_start` is high in any cycle in which `lrck_rise` or `lrck_fall` is high.
- R7: Synchronous reset (`rst`=1) clears the counter, the synchroniser and the edge registers. During reset all outputs are 0, and the first frame after reset is complete.
- R8: `slave_mode` selects at run time whether the strobes and `right_ch` come from the internal counter (0) or from the synchronised inputs (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12.288 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 = follow external clocks, 0 = generate them |
| bclk_in | input | 1 | Bit clock from the codec (slave role) |
| lrck_in | input | 1 | Word-select clock from the codec (slave role) |
| bclk_out | output | 1 | Generated bit clock (0 in slave role) |
| lrck_out | output | 1 | Generated word-select clock (0 in slave role) |
| bclk_rise | output | 1 | One-cycle strobe on bit clock rising edge |
| bclk_fall | output | 1 | One-cycle strobe on bit clock falling edge |
| lrck_rise | output | 1 | One-cycle strobe on word-select rising edge |
| lrck_fall | output | 1 | One-cycle strobe on word-select falling edge |
| right_ch | output | 1 | Current channel, 1 = right |
| frame_start | output | 1 | Strobe on either word-select edge |

## Verification
In master role, the outputs are registered counter bits. After the j-th clock edge since reset, `lrck_out` is therefore bit 7 of j, `bclk_out` is bit 2 of j, and the strobes compare bit values at j and j-1. The bench computes these arithmetically and checks them at every falling edge over two whole frames. In slave role, a level driven at a falling edge becomes the internal level two rising edges later, and its strobe lasts one cycle after that. The bench keeps a four-deep history of what it drove and compares the outputs against the entries two and three steps back.

// File: rtl/afc_pkg.sv
package afc_pkg;
  // Number of system clocks in one word-select period.
  function automatic int unsigned frame_len(input int unsigned cnt_w);
    return 32'd1 << cnt_w;
  endfunction

  // Bit clock periods per frame for a given counter width and tap.
  function automatic int unsigned bclk_per_frame(input int unsigned cnt_w,
                                                 input int unsigned tap);
    return 32'd1 << (cnt_w - 1 - tap);
  endfunction

  // Legal configuration: bit clock tap strictly below the frame tap.
  function automatic bit cfg_ok(input int unsigned cnt_w,
                                input int unsigned tap);
    return (cnt_w >= 2) && (tap < cnt_w - 1);
  endfunction
endpackage

// File: rtl/afc_divider.sv
module afc_divider #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned BCLK_TAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic bclk_tap,
  output logic lrck_tap
);
  localparam int unsigned LR_BIT = CNT_W - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else             cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign bclk_tap = cnt[BCLK_TAP];
  assign lrck_tap = cnt[LR_BIT];

  // R1: counter advances by one each cycle in master role
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!hold) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R5: counter held at zero in slave role
  assert_slave_hold_R5: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));
endmodule

// File: rtl/afc_sync.sv
module afc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/afc_edge.sv
module afc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  // R3: a rise strobe is never repeated in the following cycle
  assert_rise_one_wide_R3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/audio_frame_clk.sv
module audio_frame_clk #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned BCLK_TAP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic bclk_in,
  input  logic lrck_in,
  output logic bclk_out,
  output logic lrck_out,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic lrck_rise,
  output logic lrck_fall,
  output logic right_ch,
  output logic frame_start
);
  import afc_pkg::*;

  localparam bit CFG_OK = cfg_ok(CNT_W, BCLK_TAP);

  initial begin
    if (!CFG_OK) $display("audio_frame_clk: bit clock tap must lie below frame tap");
  end

  logic div_bclk, div_lrck;
  logic syn_bclk, syn_lrck;
  logic lvl_bclk, lvl_lrck;

  afc_divider #(.CNT_W(CNT_W), .BCLK_TAP(BCLK_TAP)) u_div (
    .clk(clk), .rst(rst), .hold(slave_mode),
    .bclk_tap(div_bclk), .lrck_tap(div_lrck)
  );

  afc_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(bclk_in), .dout(syn_bclk)
  );

  afc_sync #(.STAGES(SYNC_STAGES)) u_sync_l (
    .clk(clk), .rst(rst), .din(lrck_in), .dout(syn_lrck)
  );

  assign lvl_bclk = slave_mode ? syn_bclk : div_bclk;
  assign lvl_lrck = slave_mode ? syn_lrck : div_lrck;

  afc_edge u_edge_b (
    .clk(clk), .rst(rst), .lvl(lvl_bclk), .rise(bclk_rise), .fall(bclk_fall)
  );

  afc_edge u_edge_l (
    .clk(clk), .rst(rst), .lvl(lvl_lrck), .rise(lrck_rise), .fall(lrck_fall)
  );

  assign bclk_out    = slave_mode ? 1'b0 : div_bclk;
  assign lrck_out    = slave_mode ? 1'b0 : div_lrck;
  assign right_ch    = lvl_lrck;
  assign frame_start = lrck_rise | lrck_fall;

  // R3: in master role a bit clock rise strobe coincides with a high bit clock
  assert_bclk_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && bclk_rise) |-> bclk_out);

  // R6: a frame start always marks a change of channel
  assert_frame_on_change_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (right_ch != $past(right_ch)));

  // R5: after a full cycle in slave role the generated clocks are quiet
  assert_quiet_outs_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(slave_mode) && !slave_mode) |-> (!bclk_out && !lrck_out));

  // R2: word-select changes only when the bit clock has just fallen (master)
  assert_lr_on_bfall_R2: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && (lrck_rise || lrck_fall)) |-> bclk_fall);
endmodule

// File: tb/sim_audio_frame_clk.sv
module sim_audio_frame_clk;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0;
  logic bclk_in = 1'b0;
  logic lrck_in = 1'b0;
  logic bclk_out, lrck_out, bclk_rise, bclk_fall, lrck_rise, lrck_fall;
  logic right_ch, frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_frame_clk u0 (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .bclk_in(bclk_in), .lrck_in(lrck_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .lrck_rise(lrck_rise), .lrck_fall(lrck_fall),
    .right_ch(right_ch), .frame_start(frame_start)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Master role: j clock edges since counter start.
  task automatic check_master(input int j);
    logic eb, el, pb, pl;
    eb = 1'((j >> 2) & 1);
    el = 1'((j >> 7) & 1);
    pb = (j == 0) ? 1'b0 : 1'(((j - 1) >> 2) & 1);
    pl = (j == 0) ? 1'b0 : 1'(((j - 1) >> 7) & 1);
    chk("R1", "lrck_out", lrck_out, el);
    chk("R2", "bclk_out", bclk_out, eb);
    chk("R3", "bclk_rise", bclk_rise, eb & ~pb);
    chk("R3", "bclk_fall", bclk_fall, ~eb & pb);
    chk("R3", "lrck_rise", lrck_rise, el & ~pl);
    chk("R3", "lrck_fall", lrck_fall, ~el & pl);
    chk("R6", "right_ch", right_ch, el);
    chk("R6", "frame_start", frame_start, el ^ pl);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b1, b2, b3, l1, l2, l3;
    logic [15:0] lfsr;
    // R7: outputs quiet during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "bclk_out in reset", bclk_out, 1'b0);
    chk("R7", "lrck_out in reset", lrck_out, 1'b0);
    chk("R7", "right_ch in reset", right_ch, 1'b0);
    chk("R7", "frame_start in reset", frame_start, 1'b0);
    rst = 1'b0;

    // R1 R2 R3 R6: two full frames sweep in master role
    for (int j = 0; j < 520; j++) begin
      if (j > 0) @(negedge clk);
      check_master(j);
      if (j < 519) @(posedge clk);
    end

    // R7: reset mid-frame, first frame after reset complete
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < 300; j++) begin
      if (j > 0) begin @(posedge clk); @(negedge clk); end
      check_master(j);
    end

    // R8 R4 R5: slave role with pseudo-random input levels
    slave_mode = 1'b1;
    bclk_in = 1'b0; lrck_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    b1 = 0; b2 = 0; b3 = 0; l1 = 0; l2 = 0; l3 = 0;
    lfsr = 16'hACE1;
    for (int s = 0; s < 400; s++) begin
      @(posedge clk); @(negedge clk);
      b3 = b2; b2 = b1; b1 = bclk_in;
      l3 = l2; l2 = l1; l1 = lrck_in;
      chk("R4", "bclk_rise slave", bclk_rise, b2 & ~b3);
      chk("R4", "bclk_fall slave", bclk_fall, ~b2 & b3);
      chk("R4", "lrck_rise slave", lrck_rise, l2 & ~l3);
      chk("R4", "lrck_fall slave", lrck_fall, ~l2 & l3);
      chk("R8", "right_ch slave", right_ch, l2);
      chk("R6", "frame_start slave", frame_start, l2 ^ l3);
      chk("R5", "bclk_out slave", bclk_out, 1'b0);
      chk("R5", "lrck_out slave", lrck_out, 1'b0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bclk_in = lfsr[0];
      lrck_in = (s % 7 < 3) ? lfsr[3] : lrck_in;
    end

    // R5: back to master, counting restarts from 0
    bclk_in = 1'b1; lrck_in = 1'b1;
    slave_mode = 1'b0;
    for (int j = 1; j < 270; j++) begin
      @(posedge clk); @(negedge clk);
      check_master(j);
      if (j == 127) chk("R5", "lrck low still at 127", lrck_out, 1'b0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule